// File: doc/BRIEF.md
# Handshaked Registered Pin Port

This block drives a group of bidirectional pins through registered pad stages and exposes them as two handshaked streams. A controller pushes outgoing words that hold the value to drive on each pin and a per-pin output enable. For every accepted outgoing word, the block later returns one incoming word. That word holds the pin levels sampled while the outgoing word was on the pad. Incoming words come back in the order the outgoing words were issued, after a fixed number of cycles. A controller can subtract that latency from protocol turnaround periods.

An outgoing handshake acts as the clock enable for the pad registers. When no word is accepted, the pad keeps its previous drive, and that slot travels down a flop chain as a bubble. The bubble comes out as a cycle without an incoming word. A small first-in first-out buffer catches words that were already driven onto the pins while the consumer holds off. The outgoing ready drops as soon as the buffer could no longer absorb every word in flight. The pad is modelled as separate drive, enable and sample wires; the tri-state resolution sits outside the block.

Top module: `pinport_stream`

## Requirements
- R1: A synchronous reset sets `pad_oe` to all zeros, empties the in-flight buffer and clears every bubble-chain slot. After reset `rx_valid` is 0 and `tx_ready` is 1, and words issued before the reset are never delivered.
- R2: A word accepted in a cycle (`tx_valid` and `tx_ready` both 1) appears on `pad_o` in the following cycle, after the single output register with the default `OUT_LAT` of 1.
- R3: In a cycle with no accepted outgoing word, `pad_o` and `pad_oe` keep their values into the next cycle, whatever `tx_data` and `tx_oe` carry.
- R4: The incoming word for an outgoing word accepted in cycle n is offered in cycle n+`OUT_LAT`+`IN_LAT`. This assumes the consumer kept up and the buffer was empty. Bit b of `rx_data` equals `pad_i[b]` sampled at the end of the cycle in which that word was on the pad. With the bench's pad model, that is the driven bit where `tx_oe[b]` was 1 and the external level otherwise.
- R5: A cycle with no accepted outgoing word gives, `OUT_LAT`+`IN_LAT` cycles later, a cycle with `rx_valid` at 0 when the buffer is empty.
- R6: While `rx_valid` is 1 and `rx_ready` is 0, the offered word stays valid and unchanged. Words held by the buffer are delivered in issue order, none lost and none repeated.
- R7: The outgoing ready is 1 only when (buffered words) + (words in the pipeline) + 1 ≤ `OUT_LAT`+`IN_LAT` + (1 if an incoming word is taken this cycle). The buffered and in-flight words together never exceed the buffer depth `OUT_LAT`+`IN_LAT`.
- R8: While the buffer is empty and `rx_ready` is 1, `tx_ready` is 1, so back-to-back words flow at full rate.
- R9: The output enable of a word reaches `pad_oe` in the same cycle as its data reaches `pad_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Outgoing word present; also the pad register clock enable |
| tx_ready | output | 1 | Outgoing word can be taken this cycle |
| tx_data | input | WIDTH | Levels to drive on the pins |
| tx_oe | input | WIDTH | Per-pin output enable, 1 = drive |
| rx_valid | output | 1 | Incoming sampled word present |
| rx_ready | input | 1 | Consumer takes the incoming word |
| rx_data | output | WIDTH | Pin levels sampled for the matching outgoing word |
| pad_o | output | WIDTH | Registered drive value to the pads |
| pad_oe | output | WIDTH | Registered drive enable to the pads |
| pad_i | input | WIDTH | Levels seen on the pads |

## Verification
The bench builds the block with its defaults: four pins and one register on each side of the pad. That makes the round trip two cycles and the buffer two words deep. Four pins allow all-drive, all-receive and mixed-direction words in one table, and the incoming values can be predicted from the external levels seen one cycle after issue. The two-word buffer fills within three cycles of a stalled consumer. That exposes the point where the outgoing ready must fall, the recovery when the consumer resumes, and a reset taken while words sit in the buffer.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    // Width of a counter able to hold the values 0..n inclusive.
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of a pointer addressing n slots.
    function automatic int unsigned ptr_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pinport_pad_pipe.sv
module pinport_pad_pipe #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned OUT_LAT = 1,
    parameter int unsigned IN_LAT  = 1,
    localparam int unsigned RT     = OUT_LAT + IN_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [WIDTH-1:0] out_data,
    input  logic [WIDTH-1:0] out_oe,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] pad_i,
    output logic [RT-1:0]    tag_q,
    output logic             arrive,
    output logic [WIDTH-1:0] arrive_data
);

    // Slot occupancy chain: bit 0 is the newest slot, bit RT-1 the oldest.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q <= {tag_q[RT-2:0], issue};
        end
    end

    logic [WIDTH-1:0] drv_q [OUT_LAT];
    logic [WIDTH-1:0] ena_q [OUT_LAT];
    logic [WIDTH-1:0] smp_q [IN_LAT];

    // Output side: each stage moves only when the slot feeding it is real.
    for (genvar i = 0; i < OUT_LAT; i++) begin : g_out
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    drv_q[i] <= '0;
                    ena_q[i] <= '0;
                end else if (issue) begin
                    drv_q[i] <= out_data;
                    ena_q[i] <= out_oe;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    drv_q[i] <= '0;
                    ena_q[i] <= '0;
                end else if (tag_q[i-1]) begin
                    drv_q[i] <= drv_q[i-1];
                    ena_q[i] <= ena_q[i-1];
                end
            end
        end
    end

    // Input side: capture from the pad only for a real slot on the pad.
    for (genvar j = 0; j < IN_LAT; j++) begin : g_in
        if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    smp_q[j] <= '0;
                end else if (tag_q[OUT_LAT-1]) begin
                    smp_q[j] <= pad_i;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    smp_q[j] <= '0;
                end else if (tag_q[OUT_LAT+j-1]) begin
                    smp_q[j] <= smp_q[j-1];
                end
            end
        end
    end

    assign pad_o       = drv_q[OUT_LAT-1];
    assign pad_oe      = ena_q[OUT_LAT-1];
    assign arrive      = tag_q[RT-1];
    assign arrive_data = smp_q[IN_LAT-1];

endmodule

// File: rtl/pinport_fifo.sv
module pinport_fifo
    import pinport_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PW   = ptr_width(DEPTH),
    localparam int unsigned CW   = count_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data,
    output logic [CW-1:0]    fill_cnt
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             empty;
    logic             push;
    logic             pop;

    assign empty     = (fill_cnt == '0);
    // An arriving word passes straight through when nothing waits ahead of it.
    assign out_valid = !empty || in_valid;
    assign out_data  = empty ? in_data : mem[rd_ptr];
    assign pop       = !empty && out_ready;
    assign push      = in_valid && !(empty && out_ready);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            fill_cnt <= fill_cnt + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/pinport_credit.sv
module pinport_credit
    import pinport_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned RT    = 2,
    localparam int unsigned CW   = count_width(DEPTH)
) (
    input  logic          rst,
    input  logic [CW-1:0] fill_cnt,
    input  logic [RT-1:0] tag_q,
    input  logic          take,
    output logic          ready
);

    int unsigned committed;
    int unsigned room;

    always_comb begin
        committed = int'(fill_cnt) + $countones(tag_q) + 1;
        room      = DEPTH + (take ? 1 : 0);
        ready     = !rst && (committed <= room);
    end

endmodule

// File: rtl/pinport_stream.sv
module pinport_stream
    import pinport_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned OUT_LAT = 1,
    parameter int unsigned IN_LAT  = 1,
    localparam int unsigned RT_LAT    = OUT_LAT + IN_LAT,
    localparam int unsigned BUF_DEPTH = RT_LAT,
    localparam int unsigned CW        = count_width(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [WIDTH-1:0] tx_data,
    input  logic [WIDTH-1:0] tx_oe,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [WIDTH-1:0] rx_data,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] pad_i
);

    logic             issue;
    logic             take;
    logic [RT_LAT-1:0] tag_q;
    logic             arrive;
    logic [WIDTH-1:0] arrive_data;
    logic [CW-1:0]    fill_cnt;

    assign issue = tx_valid && tx_ready;
    assign take  = rx_valid && rx_ready;

    pinport_pad_pipe #(
        .WIDTH  (WIDTH),
        .OUT_LAT(OUT_LAT),
        .IN_LAT (IN_LAT)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .out_data   (tx_data),
        .out_oe     (tx_oe),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe),
        .pad_i      (pad_i),
        .tag_q      (tag_q),
        .arrive     (arrive),
        .arrive_data(arrive_data)
    );

    pinport_fifo #(
        .WIDTH(WIDTH),
        .DEPTH(BUF_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .in_valid (arrive),
        .in_data  (arrive_data),
        .out_valid(rx_valid),
        .out_ready(rx_ready),
        .out_data (rx_data),
        .fill_cnt (fill_cnt)
    );

    pinport_credit #(
        .DEPTH(BUF_DEPTH),
        .RT   (RT_LAT)
    ) u_credit (
        .rst     (rst),
        .fill_cnt(fill_cnt),
        .tag_q   (tag_q),
        .take    (take),
        .ready   (tx_ready)
    );

endmodule

// File: rtl/pinport_chk.sv
module pinport_chk
    import pinport_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned OUT_LAT = 1,
    parameter int unsigned IN_LAT  = 1,
    localparam int unsigned RT     = OUT_LAT + IN_LAT,
    localparam int unsigned CW     = count_width(RT)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [WIDTH-1:0] tx_data,
    input logic [WIDTH-1:0] tx_oe,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [WIDTH-1:0] rx_data,
    input logic [WIDTH-1:0] pad_o,
    input logic [WIDTH-1:0] pad_oe,
    input logic [CW-1:0]    fill_cnt,
    input logic [RT-1:0]    tag_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && !rx_valid && (fill_cnt == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(fill_cnt) + $countones(tag_q)) <= RT);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R8
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        ((fill_cnt == '0) && rx_ready) |-> tx_ready);

    if (OUT_LAT == 1) begin : g_one_out
        // R2
        drive_next_chk: assert property (@(posedge clk) disable iff (rst)
            (tx_valid && tx_ready) |=> (pad_o == $past(tx_data)));

        // R9
        oe_align_chk: assert property (@(posedge clk) disable iff (rst)
            (tx_valid && tx_ready) |=> (pad_oe == $past(tx_oe)));

        // R3
        pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(tx_valid && tx_ready) |=> ($stable(pad_o) && $stable(pad_oe)));
    end

    if (RT == 2) begin : g_rt2
        // R5
        bubble_out_chk: assert property (@(posedge clk) disable iff (rst)
            !(tx_valid && tx_ready) |=> ##1 ((fill_cnt != '0) || !rx_valid));
    end

endmodule

bind pinport_stream pinport_chk #(
    .WIDTH  (WIDTH),
    .OUT_LAT(OUT_LAT),
    .IN_LAT (IN_LAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_data (tx_data),
    .tx_oe   (tx_oe),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .rx_data (rx_data),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe),
    .fill_cnt(fill_cnt),
    .tag_q   (tag_q)
);

// File: tb/sim_pinport_stream.sv
module sim_pinport_stream;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         tx_valid;
    logic         tx_ready;
    logic [W-1:0] tx_data;
    logic [W-1:0] tx_oe;
    logic         rx_valid;
    logic         rx_ready;
    logic [W-1:0] rx_data;
    logic [W-1:0] pad_o;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_i;
    logic [W-1:0] ext;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // Pad model: a driven pin reads back its own drive, otherwise the external level.
    assign pad_i = (pad_oe & pad_o) | (~pad_oe & ext);

    pinport_stream #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .tx_data (tx_data),
        .tx_oe   (tx_oe),
        .rx_valid(rx_valid),
        .rx_ready(rx_ready),
        .rx_data (rx_data),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe),
        .pad_i   (pad_i)
    );

    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
        logic [W-1:0] oe;
        logic [W-1:0] e;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'hA, 4'hF, 4'h0},
        '{1'b1, 4'h5, 4'hF, 4'h3},
        '{1'b0, 4'hF, 4'h0, 4'h3},
        '{1'b1, 4'hC, 4'h0, 4'h9},
        '{1'b1, 4'h1, 4'h3, 4'h6},
        '{1'b0, 4'h8, 4'h8, 4'hE},
        '{1'b0, 4'h0, 4'hF, 4'h2},
        '{1'b1, 4'h7, 4'hF, 4'h0},
        '{1'b1, 4'h2, 4'h0, 4'hB},
        '{1'b0, 4'h9, 4'h9, 4'h4},
        '{1'b0, 4'h0, 4'h0, 4'h0},
        '{1'b0, 4'h0, 4'h0, 4'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] d, input logic [W-1:0] oe,
                         input logic [W-1:0] e, input logic rr);
        @(negedge clk);
        tx_valid = v;
        tx_data  = d;
        tx_oe    = oe;
        ext      = e;
        rx_ready = rr;
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] last_d;
        logic [W-1:0] last_oe;
        logic [W-1:0] exp_rx;

        rst      = 1'b1;
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_oe    = '0;
        ext      = '0;
        rx_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state straight after reset
        check("R1 pad_oe after reset", pad_oe, 0);
        check("R1 rx_valid after reset", rx_valid, 0);
        check("R1 tx_ready after reset", tx_ready, 1);

        // Vector table, consumer always ready
        last_d  = '0;
        last_oe = '0;
        for (int n = 0; n < NV; n++) begin
            drive(VECS[n].v, VECS[n].d, VECS[n].oe, VECS[n].e, 1'b1);
            check("R8 tx_ready at full rate", tx_ready, 1);
            if (n > 0 && !VECS[n-1].v) begin
                check("R3 pad_o held", pad_o, last_d);
                check("R3 pad_oe held", pad_oe, last_oe);
            end else begin
                check("R2 pad_o", pad_o, last_d);
                check("R9 pad_oe", pad_oe, last_oe);
            end
            if (n >= 2 && VECS[n-2].v) begin
                exp_rx = (VECS[n-2].oe & VECS[n-2].d) | (~VECS[n-2].oe & VECS[n-1].e);
                check("R4 rx_valid", rx_valid, 1);
                check("R4 rx_data", rx_data, exp_rx);
            end else begin
                check("R5 bubble gives no rx_valid", rx_valid, 0);
            end
            if (VECS[n].v) begin
                last_d  = VECS[n].d;
                last_oe = VECS[n].oe;
            end
        end

        // Backpressure: consumer stalls, buffer fills, ready falls, then recovers
        drive(1'b1, 4'h1, 4'hF, 4'h0, 1'b0);
        check("R7 ready with empty pipe", tx_ready, 1);
        check("R6 nothing offered yet", rx_valid, 0);
        drive(1'b1, 4'h2, 4'hF, 4'h0, 1'b0);
        check("R7 ready with one in flight", tx_ready, 1);
        drive(1'b1, 4'h3, 4'hF, 4'h0, 1'b0);
        check("R7 ready drops at two in flight", tx_ready, 0);
        check("R6 first word offered", rx_valid, 1);
        check("R6 first word data", rx_data, 4'h1);
        drive(1'b1, 4'h3, 4'hF, 4'h0, 1'b0);
        check("R7 ready low, buffer one", tx_ready, 0);
        check("R6 first word held", rx_data, 4'h1);
        drive(1'b1, 4'h3, 4'hF, 4'h0, 1'b0);
        check("R7 ready low, buffer full", tx_ready, 0);
        check("R6 held valid", rx_valid, 1);
        check("R6 held data", rx_data, 4'h1);
        check("R3 pad holds while refused", pad_o, 4'h2);
        drive(1'b1, 4'h3, 4'hF, 4'h0, 1'b1);
        check("R7 ready returns with a take", tx_ready, 1);
        check("R6 order first", rx_data, 4'h1);
        drive(1'b0, 4'h0, 4'hF, 4'h0, 1'b1);
        check("R6 order second valid", rx_valid, 1);
        check("R6 order second", rx_data, 4'h2);
        check("R2 third word on pad", pad_o, 4'h3);
        drive(1'b0, 4'h0, 4'hF, 4'h0, 1'b1);
        check("R6 order third valid", rx_valid, 1);
        check("R6 order third", rx_data, 4'h3);
        drive(1'b0, 4'h0, 4'hF, 4'h0, 1'b1);
        check("R6 no duplicate", rx_valid, 0);

        // Reset while the buffer holds words
        drive(1'b1, 4'hA, 4'hF, 4'h0, 1'b0);
        drive(1'b1, 4'hB, 4'hF, 4'h0, 1'b0);
        drive(1'b0, 4'h0, 4'h0, 4'h0, 1'b0);
        drive(1'b0, 4'h0, 4'h0, 4'h0, 1'b0);
        check("R6 word waiting before reset", rx_valid, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rx_ready = 1'b1;
        #1;
        check("R1 pad_oe cleared", pad_oe, 0);
        check("R1 buffer emptied", rx_valid, 0);
        check("R1 tx_ready after reset", tx_ready, 1);
        drive(1'b0, 4'h0, 4'h0, 4'h0, 1'b1);
        drive(1'b0, 4'h0, 4'h0, 4'h0, 1'b1);
        check("R1 old words not delivered", rx_valid, 0);

        done = 1'b1;
        finish_run();
    end

endmodule